// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a synchronous on-chip request port to an external asynchronous static RAM that holds 1M words of 16 bits. A requester presents a word address, a write flag, a write word and one enable per byte. It raises `req` while `ready` is high. The controller then runs a complete read or write cycle on the memory pins. A read ends with a single-cycle `rdValid` pulse that carries `rdData`.

Every timing window is set by a down-counter. Its reload value is the ceiling of a minimum time in nanoseconds divided by the clock period. A speed-grade parameter selects which set of minimum times applies: 55, 70 or 85 ns. Every memory pin comes straight from a flip-flop. The controller's data driver is enabled only during writes. After every read, a float interval keeps the bus released long enough for the memory's outputs to turn off.

Top module: `sramLaneCtl`

## Requirements
- R1: After reset the memory is deselected: `memCs1N`=1, `memCs2`=0, `memOeN`=1, `memWeN`=1, both byte strobes are high and `memDqOe`=0. `ready`=1 and `rdValid`=0.
- R2: The chip-select pair is asserted (`memCs1N`=0 and `memCs2`=1) only while an access is in progress. It is released whenever `ready` is high.
- R3: During a read `memOeN`=0, `memWeN`=1 and `memDqOe`=0. Bit 0 of `reqBe` maps to `memLbN` (bits 7:0) and bit 1 maps to `memUbN` (bits 15:8). A strobe is low only when its enable bit is 1.
- R4: Read data is sampled ceil(tRC/Tclk) cycles after the memory pins are driven. `rdValid` is a one-cycle pulse. A lane whose enable bit is 0 returns zero in `rdData`.
- R5: `memWeN` stays low for ceil(max(tWP, tAW, tDW)/Tclk) cycles with `memOeN`=1. Address, write data and strobes do not change while `memWeN` is low.
- R6: After `memWeN` rises, select, strobes and write data are held for at least one more cycle. The whole write lasts at least ceil(tWC/Tclk) cycles.
- R7: A write whose enable bit for a lane is 0 leaves that lane of the memory word unchanged.
- R8: After `memOeN` rises at the end of a read, `memDqOe` stays low for at least ceil(tHZ/Tclk) cycles.
- R9: `ready` is low from the cycle after a request is accepted until that access and any float interval end. A request is accepted only while `ready` is high.
- R10: `SPEED_GRADE` 0/1/2 selects these minimum times. tRC=tWC 55/70/85 ns, tWP 40/50/60, tAW 45/60/70, tDW 25/30/35 and tHZ 20/25/25 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | 16 | Write word |
| reqBe | input | 2 | Byte enables (bit 0 low byte) |
| ready | output | 1 | Controller idle, request accepted |
| rdValid | output | 1 | One-cycle read-data pulse |
| rdData | output | 16 | Read word, disabled lanes zero |
| memAddr | output | ADDR_W | Memory address |
| memCs1N | output | 1 | Active-low chip select |
| memCs2 | output | 1 | Active-high chip select |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memUbN | output | 1 | Upper byte strobe, active low |
| memLbN | output | 1 | Lower byte strobe, active low |
| memDqOut | output | 16 | Data to memory |
| memDqOe | output | 1 | Data driver enable |
| memDqIn | input | 16 | Data from memory |

## Verification
The bench builds the controller with `SPEED_GRADE`=0 and `CLK_PERIOD_PS`=10000. This gives a 6-cycle read, a 5-cycle write pulse, one recovery cycle and a 2-cycle float interval. At these values every window lands close to its nanosecond minimum. A behavioural memory model therefore catches any window cut by a single cycle as a timing violation or a garbled read. The model returns junk on unstrobed lanes and before the access time, so the zero masking and the capture cycle are both observable.

// File: rtl/sramLanePkg.sv
package sramLanePkg;

  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef struct packed {
    logic load;     // capture request fields
    logic select;   // chip selected next cycle
    logic readEn;   // output enable next cycle
    logic writeEn;  // write enable next cycle
    logic drive;    // data driver on next cycle
    logic capture;  // sample read bus this edge
  } laneCtl_t;

  function automatic int nsToCycles(input int ns, input int periodPs);
    int c;
    c = (ns * 1000 + periodPs - 1) / periodPs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // minimum times per grade, ns
  function automatic int cycleNs(input int g);
    case (g) 1: return 70; 2: return 85; default: return 55; endcase
  endfunction
  function automatic int wePulseNs(input int g);
    case (g) 1: return 50; 2: return 60; default: return 40; endcase
  endfunction
  function automatic int addrToEndNs(input int g);
    case (g) 1: return 60; 2: return 70; default: return 45; endcase
  endfunction
  function automatic int dataSetupNs(input int g);
    case (g) 1: return 30; 2: return 35; default: return 25; endcase
  endfunction
  function automatic int floatNs(input int g);
    case (g) 1: return 25; 2: return 25; default: return 20; endcase
  endfunction

endpackage

// File: rtl/sramLaneFsm.sv
module sramLaneFsm
  import sramLanePkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int SPEED_GRADE   = 0
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     req,
  input  logic     reqWrite,
  output logic     ready,
  output laneCtl_t ctl
);

  localparam int RD_CYC  = nsToCycles(cycleNs(SPEED_GRADE), CLK_PERIOD_PS);
  localparam int WP_CYC  = maxOf(nsToCycles(wePulseNs(SPEED_GRADE), CLK_PERIOD_PS),
                           maxOf(nsToCycles(addrToEndNs(SPEED_GRADE), CLK_PERIOD_PS),
                                 nsToCycles(dataSetupNs(SPEED_GRADE), CLK_PERIOD_PS)));
  localparam int WC_CYC  = nsToCycles(cycleNs(SPEED_GRADE), CLK_PERIOD_PS);
  localparam int REC_CYC = maxOf(1, WC_CYC - WP_CYC);
  localparam int HZ_CYC  = nsToCycles(floatNs(SPEED_GRADE), CLK_PERIOD_PS);
  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, WP_CYC), maxOf(REC_CYC, HZ_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_TURN, S_WRITE, S_RECOV} state_t;

  state_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    case (state)
      S_IDLE: if (req) begin
        if (reqWrite) begin
          stateNext = S_WRITE;
          cntNext   = CNT_W'(WP_CYC - 1);
        end else begin
          stateNext = S_READ;
          cntNext   = CNT_W'(RD_CYC - 1);
        end
      end
      S_READ: if (cnt == '0) begin
        stateNext = S_TURN;
        cntNext   = CNT_W'(HZ_CYC - 1);
      end else cntNext = cnt - 1'b1;
      S_TURN: if (cnt == '0) stateNext = S_IDLE;
              else cntNext = cnt - 1'b1;
      S_WRITE: if (cnt == '0) begin
        stateNext = S_RECOV;
        cntNext   = CNT_W'(REC_CYC - 1);
      end else cntNext = cnt - 1'b1;
      S_RECOV: if (cnt == '0) stateNext = S_IDLE;
               else cntNext = cnt - 1'b1;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign ready = (state == S_IDLE);

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == S_IDLE) && req;
    ctl.select  = (stateNext == S_READ) || (stateNext == S_WRITE) || (stateNext == S_RECOV);
    ctl.readEn  = (stateNext == S_READ);
    ctl.writeEn = (stateNext == S_WRITE);
    ctl.drive   = (stateNext == S_WRITE) || (stateNext == S_RECOV);
    ctl.capture = (state == S_READ) && (cnt == '0);
  end

  // R6: a write pulse is always followed by a recovery state
  a_r6_recover_follows: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WRITE && !ctl.writeEn) |=> (state == S_RECOV));

endmodule

// File: rtl/sramLaneDp.sv
module sramLaneDp
  import sramLanePkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int HZ_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCs1N,
  output logic              memCs2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memLaneN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int HZ_W = $clog2(HZ_CYC + 1);

  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] laneMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beQ      <= '0;
      memAddr  <= '0;
      memDqOut <= '0;
    end else if (ctl.load) begin
      beQ      <= reqBe;
      memAddr  <= reqAddr;
      memDqOut <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCs1N <= 1'b1;
      memCs2  <= 1'b0;
      memOeN  <= 1'b1;
      memWeN  <= 1'b1;
      memDqOe <= 1'b0;
    end else begin
      memCs1N <= !ctl.select;
      memCs2  <= ctl.select;
      memOeN  <= !ctl.readEn;
      memWeN  <= !ctl.writeEn;
      memDqOe <= ctl.drive;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic enNext;
    assign enNext = ctl.load ? reqBe[i] : beQ[i];
    always_ff @(posedge clk) begin
      if (!rstN) memLaneN[i] <= 1'b1;
      else       memLaneN[i] <= !(ctl.select && enNext);
    end
    assign laneMask[i*8 +: 8] = {8{beQ[i]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= ctl.capture;
      if (ctl.capture) rdData <= memDqIn & laneMask;
    end
  end

  // cycles since output enable was released, saturating
  logic [HZ_W-1:0] oeOffCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                       oeOffCnt <= HZ_W'(HZ_CYC);
    else if (!memOeN)                oeOffCnt <= '0;
    else if (oeOffCnt < HZ_W'(HZ_CYC)) oeOffCnt <= oeOffCnt + 1'b1;
  end

  // R3: never drive the bus while the memory may drive it
  a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDqOe);
  // R5: write enable only with outputs disabled and the chip selected
  a_r5_we_excludes_oe: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCs1N && memCs2));
  // R5: address, data and strobes stable across the pulse
  a_r5_pulse_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memDqOut) && $stable(memLaneN)));
  // R4: read valid is a single-cycle pulse
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);
  // R8: driver waits out the float time after a read
  a_r8_float_gap: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (oeOffCnt >= HZ_W'(HZ_CYC)));

endmodule

// File: rtl/sramLaneCtl.sv
module sramLaneCtl
  import sramLanePkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int SPEED_GRADE   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqBe,
  output logic              ready,
  output logic              rdValid,
  output logic [15:0]       rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCs1N,
  output logic              memCs2,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [15:0]       memDqOut,
  output logic              memDqOe,
  input  logic [15:0]       memDqIn
);

  localparam int HZ_CYC = nsToCycles(floatNs(SPEED_GRADE), CLK_PERIOD_PS);

  laneCtl_t        ctl;
  logic [LANES-1:0] laneN;

  sramLaneFsm #(.CLK_PERIOD_PS(CLK_PERIOD_PS), .SPEED_GRADE(SPEED_GRADE)) u_fsm (
    .clk(clk), .rstN(rstN), .req(req), .reqWrite(reqWrite),
    .ready(ready), .ctl(ctl)
  );

  sramLaneDp #(.ADDR_W(ADDR_W), .HZ_CYC(HZ_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memCs1N(memCs1N), .memCs2(memCs2),
    .memOeN(memOeN), .memWeN(memWeN), .memLaneN(laneN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[1];

  // R2 / R9: an idle controller leaves the memory deselected
  a_r9_ready_deselected: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (memCs1N && !memCs2 && memWeN && memOeN));

endmodule

// File: tb/sim_sramLaneCtl.sv
`timescale 1ns/1ps
module sim_sramLaneCtl;

  localparam int CLK_NS = 10;
  localparam int HALF   = CLK_NS / 2;
  // grade 0 minimum times, ns
  localparam int T_RC = 55, T_WP = 40, T_AW = 45, T_DW = 25, T_WC = 55, T_HZ = 20, T_OE = 25;
  localparam int RD_C = (T_RC + CLK_NS - 1) / CLK_NS;
  localparam int WP_C = (T_AW + CLK_NS - 1) / CLK_NS;  // largest of WP/AW/DW
  localparam int WC_C = (T_WC + CLK_NS - 1) / CLK_NS;
  localparam int HZ_C = (T_HZ + CLK_NS - 1) / CLK_NS;

  logic clk = 0, rstN = 0;
  logic req = 0, reqWrite = 0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic ready, rdValid, memCs1N, memCs2, memOeN, memWeN, memUbN, memLbN, memDqOe;
  logic [15:0] rdData, memDqOut, memDqIn;
  logic [19:0] memAddr;

  always #(HALF) clk = ~clk;

  sramLaneCtl #(.ADDR_W(20), .CLK_PERIOD_PS(CLK_NS*1000), .SPEED_GRADE(0)) u0 (
    .clk(clk), .rstN(rstN), .req(req), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .ready(ready), .rdValid(rdValid),
    .rdData(rdData), .memAddr(memAddr), .memCs1N(memCs1N), .memCs2(memCs2),
    .memOeN(memOeN), .memWeN(memWeN), .memUbN(memUbN), .memLbN(memLbN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int nChecks = 0, nFails = 0;

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [15:0] mem [0:255];
  logic [15:0] modelOut = 16'hA5A5;
  longint addrT = 0, oeFallT = 0, oeRiseT = -1000, weFallT = 0, dataT = 0;
  logic [19:0] prevAddr = '0;
  logic [15:0] prevData = '0;
  logic prevWeN = 1, prevOeN = 1;
  int violations = 0, contention = 0;
  assign memDqIn = modelOut;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

  wire sel = !memCs1N && memCs2;

  always @(negedge clk) begin
    longint now;
    now = $time;
    if (memAddr != prevAddr) addrT = now;
    if (memDqOut != prevData) dataT = now;
    if (prevOeN && !memOeN) oeFallT = now;
    if (!prevOeN && memOeN) oeRiseT = now;
    if (prevWeN && !memWeN) weFallT = now;
    if (!prevWeN && memWeN && sel) begin
      if (now - weFallT < T_WP || now - addrT < T_AW || now - dataT < T_DW) violations++;
      if (!memLbN) mem[memAddr[7:0]][7:0]  = memDqOut[7:0];
      if (!memUbN) mem[memAddr[7:0]][15:8] = memDqOut[15:8];
    end
    if (sel && !memOeN && memWeN &&
        (now - addrT + CLK_NS >= T_RC) && (now - oeFallT + CLK_NS >= T_OE)) begin
      modelOut[7:0]  = memLbN ? 8'hC3 : mem[memAddr[7:0]][7:0];
      modelOut[15:8] = memUbN ? 8'h3C : mem[memAddr[7:0]][15:8];
    end else modelOut = 16'hA5A5;
    if (memDqOe && ((sel && !memOeN) || (now - oeRiseT < T_HZ))) contention++;
    prevAddr = memAddr; prevData = memDqOut; prevOeN = memOeN; prevWeN = memWeN;
  end

  // ---------------- port monitor ----------------
  int cyc = 0, weRun = 0, weLast = 0, selRun = 0, selLast = 0;
  int oeRiseCyc = -100, gapLast = 100, busyReady = 0, oeWeBoth = 0;
  logic lbSeen = 1, ubSeen = 1, prevMonOe = 1, prevMonDq = 0;
  always @(negedge clk) begin
    cyc++;
    if (!memWeN) weRun++; else if (weRun != 0) begin weLast = weRun; weRun = 0; end
    if (sel) selRun++; else if (selRun != 0) begin selLast = selRun; selRun = 0; end
    if (!memOeN) begin lbSeen = memLbN; ubSeen = memUbN; end
    if (!prevMonOe && memOeN) oeRiseCyc = cyc;
    if (!prevMonDq && memDqOe) gapLast = cyc - oeRiseCyc;
    if (ready && sel) busyReady++;
    if (!memOeN && !memWeN) oeWeBoth++;
    prevMonOe = memOeN; prevMonDq = memDqOe;
  end

  // ---------------- access tasks ----------------
  task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    while (!ready) @(negedge clk);
    req = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    @(posedge clk);
    @(negedge clk);
    req = 0;
  endtask

  task automatic doWrite(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    issue(1, a, d, be);
    check(!ready, "R9 busy after accept", ready, 0);
    while (!ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doRead(input logic [19:0] a, input logic [1:0] be,
                        output logic [15:0] d, output int lat);
    lat = 0;
    issue(0, a, 16'h0, be);
    while (!rdValid && lat < 50) begin @(negedge clk); lat++; end
    d = rdData;
    @(negedge clk);
    check(!rdValid, "R4 valid single cycle", rdValid, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    check(memCs1N && !memCs2, "R1 deselected", {memCs1N, memCs2}, 2'b10);
    check(memOeN && memWeN && memLbN && memUbN, "R1 controls idle",
          {memOeN, memWeN, memLbN, memUbN}, 4'hF);
    check(!memDqOe && ready && !rdValid, "R1 ready no drive",
          {memDqOe, ready, rdValid}, 3'b010);
  endtask

  task automatic t_word;
    logic [15:0] d; int lat;
    doWrite(20'h00012, 16'hBEEF, 2'b11);
    check(weLast == WP_C, "R5 R10 we pulse cycles", weLast, WP_C);
    check(selLast >= WC_C && selLast == WP_C + 1, "R6 write cycle length", selLast, WP_C + 1);
    doRead(20'h00012, 2'b11, d, lat);
    check(lat == RD_C, "R4 read latency", lat, RD_C);
    check(d == 16'hBEEF, "R4 word read data", d, 16'hBEEF);
    check(!lbSeen && !ubSeen, "R3 both strobes on word read", {ubSeen, lbSeen}, 0);
    check(memCs1N && !memCs2, "R2 released after access", {memCs1N, memCs2}, 2'b10);
  endtask

  task automatic t_lanes;
    logic [15:0] d; int lat;
    doWrite(20'h00030, 16'h1122, 2'b11);
    doWrite(20'h00030, 16'hAA77, 2'b01);
    doRead(20'h00030, 2'b11, d, lat);
    check(d == 16'h1177, "R7 lower-only write keeps upper", d, 16'h1177);
    doWrite(20'h00030, 16'h55EE, 2'b10);
    doRead(20'h00030, 2'b11, d, lat);
    check(d == 16'h5577, "R7 upper-only write keeps lower", d, 16'h5577);
    doRead(20'h00030, 2'b10, d, lat);
    check(d == 16'h5500, "R4 disabled lower lane reads zero", d, 16'h5500);
    check(lbSeen && !ubSeen, "R3 upper strobe only", {ubSeen, lbSeen}, 2'b01);
    doRead(20'h00030, 2'b01, d, lat);
    check(d == 16'h0077, "R4 disabled upper lane reads zero", d, 16'h0077);
    check(!lbSeen && ubSeen, "R3 lower strobe only", {ubSeen, lbSeen}, 2'b10);
  endtask

  task automatic t_turnaround;
    logic [15:0] d; int lat;
    doWrite(20'h000F0, 16'h0F0F, 2'b11);
    doRead(20'h000F0, 2'b11, d, lat);
    issue(1, 20'h000F1, 16'hC0DE, 2'b11);
    while (!ready) @(negedge clk);
    @(negedge clk);
    check(gapLast >= HZ_C, "R8 float gap before drive", gapLast, HZ_C);
    doRead(20'h000F1, 2'b11, d, lat);
    check(d == 16'hC0DE, "R8 back-to-back write data", d, 16'hC0DE);
    doRead(20'h000F0, 2'b11, d, lat);
    check(d == 16'h0F0F, "R7 neighbour word untouched", d, 16'h0F0F);
  endtask

  // ---------------- main and watchdog ----------------
  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_word();
    t_lanes();
    t_turnaround();
    check(violations == 0, "R5 memory timing violations", violations, 0);
    check(contention == 0, "R8 bus contention", contention, 0);
    check(busyReady == 0, "R9 ready while selected", busyReady, 0);
    check(oeWeBoth == 0, "R3 oe and we together", oeWeBoth, 0);
    done = 1;
  end

  initial begin
    int t;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    if (!done) check(0, "watchdog expired", t, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule